// File: doc/BRIEF.md
# Two-Word Command Port Latch

This block decodes the control port of a video display processor. A host on a 16-bit bus sets up a memory access with two control writes in a row. The first word supplies the low fourteen address bits and the two low bits of a six-bit access code. The second word supplies the three high address bits and the upper access-code bits. Both words go into shadow latches. The live address and live access code that the memory side consumes take the latched values only when the pending state ends.

Pending ends on one of four events: the second control write, a data-port write, a data-port read, or a control-port read. The high address bits in the shadow latch survive later first words. A DMA-enable input decides whether the top access-code bit can be rewritten. A first word tagged as a register write does not start a two-word sequence. Instead it produces a one-cycle strobe with a register index and a data byte.

The block also keeps a read-fetched flag and asks for a read prefetch whenever the live code selects a read and no fetched word is held. It assembles the control-port read value with its upper six bits taken from an open-bus input.

Top module: `cmdp_latch`

## Requirements
- R1: After reset, pending is 0, the read-fetched flag is 0, and the live address, live code and both shadow latches are 0. The register strobe is 0.
- R2: A control write with pending 0 and word[15:14] != 2'b10 is a first word. It loads address latch [13:0] from word[13:0] and code latch [1:0] from word[15:14]. It keeps address latch [16:14] and code latch [5:2], and it sets pending.
- R3: A control write with pending 0 and word[15:14] == 2'b10 is a register write. On the next cycle the block gives a one-cycle reg_wr pulse with reg_idx = word[12:8] and reg_val = word[7:0]. Pending stays 0 and the live registers do not change.
- R4: A control write with pending 1 is a second word. It loads address latch [16:14] from word[2:0].
- R5: On a second word with dma_en = 1, code latch [5:2] takes word[7:4] and code latch [1:0] is kept.
- R6: On a second word with dma_en = 0, code latch [4:2] takes word[6:4], and code latch bits 5 and [1:0] are kept.
- R7: The cycle after pending clears, live_addr and live_code equal the shadow latches, including any update made by that same write. At all other times they hold their values.
- R8: With pending 1, a control read, data write or data read clears pending. With pending 0 these strobes change no state.
- R9: fetch_ack sets the read-fetched flag. Any event that clears pending clears the flag, and the clear wins over a simultaneous fetch_ack.
- R10: prefetch_req is 1 exactly when live_code bit 0 is 0 and the read-fetched flag is 0, whatever the pending state.
- R11: status_rdata[15:10] equals open_bus and status_rdata[9:0] equals status_low, combinationally.
- R12: When ctl_wr is asserted in the same cycle as ctl_rd, dat_wr or dat_rd, only the control write is acted on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_wr | input | 1 | Control-port write strobe |
| ctl_rd | input | 1 | Control-port read strobe |
| dat_wr | input | 1 | Data-port write strobe |
| dat_rd | input | 1 | Data-port read strobe |
| host_wdata | input | 16 | Host write word |
| dma_en | input | 1 | DMA enable; allows code bit 5 to change |
| fetch_ack | input | 1 | Memory side has fetched a read word |
| open_bus | input | 6 | Open-bus value for status bits 15:10 |
| status_low | input | 10 | Status flags for bits 9:0 |
| status_rdata | output | 16 | Control-port read value |
| live_addr | output | 17 | Live memory address |
| live_code | output | 6 | Live access code |
| pending | output | 1 | Waiting for the second command word |
| prefetch_req | output | 1 | Read prefetch request |
| reg_wr | output | 1 | Register write strobe |
| reg_idx | output | 5 | Register index |
| reg_val | output | 8 | Register data byte |

## Verification
The assertions check on every cycle the properties that hold at any time. The live registers move only on a pending-clearing event, and on that event they take the latch values. The read-fetched flag drops whenever pending clears. The high address bits survive a first word, code bit 5 survives a second word while DMA is off, and a register strobe never comes with pending set. Only the bench scenarios can show the exact bit mapping of each word into the address and code. They also show that the latched high bits carry from one command into the next, which of the four strobes end a sequence, and the strobe priority when several arrive in the same cycle.

// File: rtl/cmdp_pkg.sv
package cmdp_pkg;
    localparam int CMD_W  = 16;
    localparam int ADDR_W = 17;
    localparam int LO_W   = 14;
    localparam int CODE_W = 6;
    localparam int IDX_W  = 5;
    localparam int VAL_W  = 8;
    localparam int OPEN_W = 6;

    typedef struct packed {
        logic              pending;
        logic              fetched;
        logic [ADDR_W-1:0] addr_lat;
        logic [CODE_W-1:0] code_lat;
        logic [ADDR_W-1:0] live_addr;
        logic [CODE_W-1:0] live_code;
        logic              reg_wr;
        logic [IDX_W-1:0]  reg_idx;
        logic [VAL_W-1:0]  reg_val;
    } cmdp_state_t;
endpackage

// File: rtl/cmdp_word_dec.sv
module cmdp_word_dec #(
    parameter int CMD_W  = cmdp_pkg::CMD_W,
    parameter int ADDR_W = cmdp_pkg::ADDR_W,
    parameter int LO_W   = cmdp_pkg::LO_W,
    parameter int CODE_W = cmdp_pkg::CODE_W,
    parameter int IDX_W  = cmdp_pkg::IDX_W,
    parameter int VAL_W  = cmdp_pkg::VAL_W
) (
    input  logic [CMD_W-1:0]         word,
    output logic                     is_reg,
    output logic [LO_W-1:0]          lo_addr,
    output logic [ADDR_W-LO_W-1:0]   hi_addr,
    output logic [1:0]               code_lo,
    output logic [CODE_W-1:0]        code_src,
    output logic [IDX_W-1:0]         idx,
    output logic [VAL_W-1:0]         val
);
    localparam int HI_W = ADDR_W - LO_W;

    always_comb begin
        is_reg   = (word[CMD_W-1 -: 2] == 2'b10);
        code_lo  = word[CMD_W-1 -: 2];
        lo_addr  = word[LO_W-1:0];
        hi_addr  = word[HI_W-1:0];
        code_src = word[CODE_W+1:2];
        idx      = word[VAL_W+IDX_W-1:VAL_W];
        val      = word[VAL_W-1:0];
    end
endmodule

// File: rtl/cmdp_status.sv
module cmdp_status #(
    parameter int CMD_W  = cmdp_pkg::CMD_W,
    parameter int OPEN_W = cmdp_pkg::OPEN_W
) (
    input  logic [OPEN_W-1:0]       open_bus,
    input  logic [CMD_W-OPEN_W-1:0] status_low,
    output logic [CMD_W-1:0]        status_rdata
);
    always_comb begin
        status_rdata = {open_bus, status_low};
    end
endmodule

// File: rtl/cmdp_seq.sv
module cmdp_seq
    import cmdp_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   ctl_wr,
    input  logic                   ctl_rd,
    input  logic                   dat_wr,
    input  logic                   dat_rd,
    input  logic                   dma_en,
    input  logic                   fetch_ack,
    input  logic                   is_reg,
    input  logic [LO_W-1:0]        lo_addr,
    input  logic [ADDR_W-LO_W-1:0] hi_addr,
    input  logic [1:0]             code_lo,
    input  logic [CODE_W-1:0]      code_src,
    input  logic [IDX_W-1:0]       idx,
    input  logic [VAL_W-1:0]       val,
    output cmdp_state_t            st_q,
    output logic                   prefetch_req
);
    localparam logic [CODE_W-1:0] KEEP_DMA   = CODE_W'(6'h03);
    localparam logic [CODE_W-1:0] KEEP_NODMA = CODE_W'(6'h23);

    cmdp_state_t       st_d;
    logic              clr_evt;
    logic [CODE_W-1:0] keep;

    always_comb begin
        st_d        = st_q;
        st_d.reg_wr = 1'b0;
        clr_evt     = 1'b0;
        keep        = dma_en ? KEEP_DMA : KEEP_NODMA;
        if (ctl_wr) begin
            if (!st_q.pending) begin
                st_d.addr_lat[LO_W-1:0] = lo_addr;
                st_d.code_lat[1:0]      = code_lo;
                if (is_reg) begin
                    st_d.reg_wr  = 1'b1;
                    st_d.reg_idx = idx;
                    st_d.reg_val = val;
                end else begin
                    st_d.pending = 1'b1;
                end
            end else begin
                st_d.addr_lat[ADDR_W-1:LO_W] = hi_addr;
                st_d.code_lat = (st_q.code_lat & keep) | (code_src & ~keep);
                clr_evt = 1'b1;
            end
        end else if (st_q.pending && (ctl_rd || dat_wr || dat_rd)) begin
            clr_evt = 1'b1;
        end
        if (fetch_ack) begin
            st_d.fetched = 1'b1;
        end
        if (clr_evt) begin
            st_d.pending   = 1'b0;
            st_d.fetched   = 1'b0;
            st_d.live_addr = st_d.addr_lat;
            st_d.live_code = st_d.code_lat;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign prefetch_req = !st_q.live_code[0] && !st_q.fetched;

    // R7: on a clearing event the live registers take the latch contents
    p_live_copy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pending && clr_evt) |=>
            (st_q.live_addr == st_q.addr_lat) && (st_q.live_code == st_q.code_lat));

    // R7: without a clearing event the live registers hold
    p_live_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_q.pending && clr_evt) |=>
            $stable(st_q.live_addr) && $stable(st_q.live_code));

    // R9: leaving the pending state drops the read-fetched flag
    p_fetch_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.pending) |-> !st_q.fetched);

    // R2: a first word keeps the high address bits
    p_hi_kept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && !st_q.pending) |=>
            (st_q.addr_lat[ADDR_W-1:LO_W] == $past(st_q.addr_lat[ADDR_W-1:LO_W])));

    // R6: with DMA off a second word cannot change the top code bit
    p_code_top_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && st_q.pending && !dma_en) |=>
            (st_q.code_lat[CODE_W-1] == $past(st_q.code_lat[CODE_W-1])));

    // R3: a register strobe never comes with pending set
    p_reg_no_pend_r3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.reg_wr |-> !st_q.pending);
endmodule

// File: rtl/cmdp_latch.sv
module cmdp_latch
    import cmdp_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      ctl_wr,
    input  logic                      ctl_rd,
    input  logic                      dat_wr,
    input  logic                      dat_rd,
    input  logic [CMD_W-1:0]          host_wdata,
    input  logic                      dma_en,
    input  logic                      fetch_ack,
    input  logic [OPEN_W-1:0]         open_bus,
    input  logic [CMD_W-OPEN_W-1:0]   status_low,
    output logic [CMD_W-1:0]          status_rdata,
    output logic [ADDR_W-1:0]         live_addr,
    output logic [CODE_W-1:0]         live_code,
    output logic                      pending,
    output logic                      prefetch_req,
    output logic                      reg_wr,
    output logic [IDX_W-1:0]          reg_idx,
    output logic [VAL_W-1:0]          reg_val
);
    logic                   is_reg;
    logic [LO_W-1:0]        lo_addr;
    logic [ADDR_W-LO_W-1:0] hi_addr;
    logic [1:0]             code_lo;
    logic [CODE_W-1:0]      code_src;
    logic [IDX_W-1:0]       idx;
    logic [VAL_W-1:0]       val;
    cmdp_state_t            st_q;

    cmdp_word_dec u_dec (
        .word     (host_wdata),
        .is_reg   (is_reg),
        .lo_addr  (lo_addr),
        .hi_addr  (hi_addr),
        .code_lo  (code_lo),
        .code_src (code_src),
        .idx      (idx),
        .val      (val)
    );

    cmdp_seq u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .ctl_wr       (ctl_wr),
        .ctl_rd       (ctl_rd),
        .dat_wr       (dat_wr),
        .dat_rd       (dat_rd),
        .dma_en       (dma_en),
        .fetch_ack    (fetch_ack),
        .is_reg       (is_reg),
        .lo_addr      (lo_addr),
        .hi_addr      (hi_addr),
        .code_lo      (code_lo),
        .code_src     (code_src),
        .idx          (idx),
        .val          (val),
        .st_q         (st_q),
        .prefetch_req (prefetch_req)
    );

    cmdp_status u_stat (
        .open_bus     (open_bus),
        .status_low   (status_low),
        .status_rdata (status_rdata)
    );

    assign live_addr = st_q.live_addr;
    assign live_code = st_q.live_code;
    assign pending   = st_q.pending;
    assign reg_wr    = st_q.reg_wr;
    assign reg_idx   = st_q.reg_idx;
    assign reg_val   = st_q.reg_val;
endmodule

// File: tb/sim_cmdp_latch.sv
module sim_cmdp_latch;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 5;

    localparam logic [15:0] V_W1   [NV] = '{16'h4123, 16'h3FFF, 16'hC000, 16'h0005, 16'h4000};
    localparam logic [15:0] V_W2   [NV] = '{16'h0002, 16'h00F7, 16'h0030, 16'h0081, 16'h00C4};
    localparam logic        V_DMA  [NV] = '{1'b1, 1'b1, 1'b0, 1'b1, 1'b0};
    localparam logic [16:0] V_ADDR [NV] = '{17'h08123, 17'h1FFFF, 17'h00000, 17'h04005, 17'h10000};
    localparam logic [5:0]  V_CODE [NV] = '{6'h01, 6'h3C, 6'h2F, 6'h20, 6'h31};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_wr = 1'b0, ctl_rd = 1'b0, dat_wr = 1'b0, dat_rd = 1'b0;
    logic [15:0] host_wdata = '0;
    logic        dma_en = 1'b0, fetch_ack = 1'b0;
    logic [5:0]  open_bus = '0;
    logic [9:0]  status_low = '0;
    logic [15:0] status_rdata;
    logic [16:0] live_addr;
    logic [5:0]  live_code;
    logic        pending, prefetch_req, reg_wr;
    logic [4:0]  reg_idx;
    logic [7:0]  reg_val;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cmdp_latch u0 (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_rd(ctl_rd),
        .dat_wr(dat_wr), .dat_rd(dat_rd), .host_wdata(host_wdata),
        .dma_en(dma_en), .fetch_ack(fetch_ack), .open_bus(open_bus),
        .status_low(status_low), .status_rdata(status_rdata),
        .live_addr(live_addr), .live_code(live_code), .pending(pending),
        .prefetch_req(prefetch_req), .reg_wr(reg_wr), .reg_idx(reg_idx),
        .reg_val(reg_val)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // drive for one cycle on the falling edge; return on the next falling edge
    task automatic ctl_write(input logic [15:0] w);
        @(negedge clk);
        host_wdata = w; ctl_wr = 1'b1;
        @(negedge clk);
        ctl_wr = 1'b0;
    endtask

    task automatic strobe(input int which);
        @(negedge clk);
        case (which)
            0: ctl_rd = 1'b1;
            1: dat_wr = 1'b1;
            2: dat_rd = 1'b1;
            default: fetch_ack = 1'b1;
        endcase
        @(negedge clk);
        ctl_rd = 1'b0; dat_wr = 1'b0; dat_rd = 1'b0; fetch_ack = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 pending", pending, 0);
        check("R1 addr", live_addr, 0);
        check("R1 code", live_code, 0);
        check("R1 reg_wr", reg_wr, 0);
        check("R1 prefetch", prefetch_req, 1);

        // table walk: R2, R4, R5, R6, R7
        for (int i = 0; i < NV; i++) begin
            logic [16:0] prev_a;
            prev_a = live_addr;
            dma_en = V_DMA[i];
            ctl_write(V_W1[i]);
            check("R2 pending set", pending, 1);
            check("R7 live held", live_addr, prev_a);
            ctl_write(V_W2[i]);
            check("R4 addr", live_addr, V_ADDR[i]);
            check(V_DMA[i] ? "R5 code" : "R6 code", live_code, V_CODE[i]);
            check("R7 pending clear", pending, 0);
            check("R10 prefetch", prefetch_req, !V_CODE[i][0]);
        end

        // R3 register write
        ctl_write(16'h8A5C);
        check("R3 strobe", reg_wr, 1);
        check("R3 idx", reg_idx, 5'h0A);
        check("R3 val", reg_val, 8'h5C);
        check("R3 pending", pending, 0);
        check("R3 live", live_addr, 17'h10000);
        @(negedge clk);
        check("R3 one cycle", reg_wr, 0);

        // R2 high bits kept, R8 control read clears
        ctl_write(16'h0111);
        strobe(0);
        check("R2 hi kept", live_addr, 17'h10111);
        check("R8 ctl_rd code", live_code, 6'h30);
        check("R8 ctl_rd pend", pending, 0);

        ctl_write(16'h4222);
        strobe(1);
        check("R8 dat_wr addr", live_addr, 17'h10222);
        check("R8 dat_wr code", live_code, 6'h31);

        ctl_write(16'h0333);
        strobe(2);
        check("R8 dat_rd addr", live_addr, 17'h10333);
        check("R8 dat_rd code", live_code, 6'h30);

        // R8 ignored when not pending
        strobe(2);
        strobe(1);
        check("R8 ignored addr", live_addr, 17'h10333);
        check("R8 ignored pend", pending, 0);

        // R9 fetched flag
        check("R9 before", prefetch_req, 1);
        strobe(3);
        check("R9 set", prefetch_req, 0);
        ctl_write(16'h0000);
        check("R10 pending does not matter", prefetch_req, 0);
        @(negedge clk);
        fetch_ack = 1'b1; dat_wr = 1'b1;
        @(negedge clk);
        fetch_ack = 1'b0; dat_wr = 1'b0;
        check("R9 clear wins", prefetch_req, 1);
        check("R9 addr", live_addr, 17'h10000);

        // R10 prefetch while pending
        ctl_write(16'h4444);
        check("R10 pending", pending, 1);
        check("R10 prefetch while pending", prefetch_req, 1);
        strobe(0);
        check("R10 after clear", prefetch_req, 0);

        // R12 control write wins over a simultaneous data read
        @(negedge clk);
        host_wdata = 16'h0100; ctl_wr = 1'b1; dat_rd = 1'b1;
        @(negedge clk);
        ctl_wr = 1'b0; dat_rd = 1'b0;
        check("R12 pending", pending, 1);
        strobe(0);
        check("R12 addr", live_addr, 17'h10100);
        check("R12 code", live_code, 6'h30);

        // R11 status assembly
        open_bus = 6'h29; status_low = 10'h155;
        #1;
        check("R11 status", status_rdata, 16'hA555);
        open_bus = 6'h3F; status_low = 10'h000;
        #1;
        check("R11 status b", status_rdata, 16'hFC00);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule